// File: doc/BRIEF.md
# Alarm-Sequenced Power-Enable Controller

This block owns the pin that tells an external power-management device to keep the system supplied. Software programs one 32-bit control word. Once software arms sequencing through that word, a match pulse from the second alarm of the real-time clock switches the power-enable pin to its off level. While power is off, four external wakeup pins are watched. Each pin has its own enable bit and its own polarity bit. When any enabled pin reaches its active level, power comes back on and the block emits a one-cycle wakeup event.

The wakeup pins are asynchronous to the block clock, so each one passes through a two-flop synchronizer before polarity and enable are applied. Filtering of noisy pins and the timing of the external power device are left to the surrounding system. The control word is written through a simple write port that carries an address and byte strobes. Only full-word writes to the control offset are accepted.

Top module: `pmic_pwr_ctrl`

## Requirements
- R1: After reset, pwr_en is 1, wake_evt is 0 and the control word is all zero, so sequencing is disarmed.
- R2: A write changes the control word only when cfg_addr is 0x98 and all four cfg_be bits are 1. A write to any other address, or with any strobe clear, is ignored.
- R3: While control bit 16 is 0, pwr_en stays 1 even when alarm_hit pulses.
- R4: While control bit 16 is 1 and power is on, an alarm_hit pulse sampled on a rising edge drives pwr_en to 0 from that edge onward.
- R5: While power is off, an enabled wakeup pin at its active level drives pwr_en back to 1 on the third rising edge after the pin changes (two synchronizer stages, then the state register). wake_evt is 1 for exactly that one cycle. Control bits 0 to 3 enable pins 0 to 3.
- R6: Control bits 4 to 7 set the polarity of pins 0 to 3. A set bit makes the pin active-low, and a clear bit makes it active-high.
- R7: A pin whose enable bit is 0, or an enabled pin at its inactive level, leaves power off and wake_evt at 0.
- R8: Clearing bit 16 while power is off returns pwr_en to 1 on the rising edge after the write is accepted, and wake_evt stays 0.
- R9: An active, enabled wakeup pin while power is on causes no wake_evt and leaves pwr_en at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_addr | input | 8 | Byte offset of the write |
| cfg_be | input | 4 | Byte strobes; all four must be set |
| cfg_wdata | input | 32 | Write data |
| alarm_hit | input | 1 | One-cycle second-alarm match pulse |
| wake_pin | input | 4 | Asynchronous external wakeup pins |
| pwr_en | output | 1 | Power-enable pin, 1 means on |
| wake_evt | output | 1 | One-cycle pulse when a wakeup restores power |

## Verification
The assertions check on every cycle the following: rejected writes leave the control word unchanged, a disarmed controller holds power on, an armed alarm switches power off, and power that is off stays off unless a wakeup is seen. They also check that every wake_evt coincides with a rise of pwr_en. Only the bench scenarios can show the parts that depend on what happens at the pins: the exact three-edge latency through the synchronizer, the polarity encoding of each pin, pins that are masked, and the behaviour when sequencing is disarmed while power is off.

// File: rtl/pmic_pwr_pkg.sv
package pmic_pwr_pkg;

    localparam int WAKE_N  = 4;
    localparam int SEQ_BIT = 16;

    typedef enum logic {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_state_e;

    typedef struct packed {
        logic              seq_en;
        logic [WAKE_N-1:0] act_low;
        logic [WAKE_N-1:0] enable;
    } pwr_cfg_t;

    localparam pwr_cfg_t CFG_RESET = '{seq_en: 1'b0, act_low: '0, enable: '0};

    function automatic pwr_cfg_t unpack_cfg(input logic [31:0] word);
        pwr_cfg_t c;
        c.seq_en  = word[SEQ_BIT];
        c.enable  = word[WAKE_N-1:0];
        c.act_low = word[2*WAKE_N-1:WAKE_N];
        return c;
    endfunction

endpackage

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg
    import pmic_pwr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h98
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0] wdata,
    output pwr_cfg_t          cfg
);
    logic accept;

    assign accept = we && (addr == OFFSET) && (&be);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RESET;
        else if (accept)
            cfg <= unpack_cfg(wdata[31:0]);
    end

    // R2
    cfg_addr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr != OFFSET) |=> $stable(cfg));

    // R2
    cfg_part_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !(&be)) |=> $stable(cfg));

endmodule

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst)
                    chain <= '0;
                else
                    chain <= {chain[STAGES-2:0], pin_async[i]};
            end
            assign pin_sync[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] act_low,
    input  logic [WIDTH-1:0] enable,
    output logic             wake_any
);
    logic [WIDTH-1:0] level_ok;

    always_comb begin
        level_ok = (pin_sync ^ act_low) & enable;
        wake_any = |level_ok;
    end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import pmic_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic seq_en,
    input  logic alarm_hit,
    input  logic wake_any,
    output logic pwr_en,
    output logic wake_evt
);
    pwr_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PWR_ON;
            wake_evt <= 1'b0;
        end else begin
            wake_evt <= 1'b0;
            if (!seq_en)
                state <= PWR_ON;
            else if (state == PWR_ON && alarm_hit)
                state <= PWR_OFF;
            else if (state == PWR_OFF && wake_any) begin
                state    <= PWR_ON;
                wake_evt <= 1'b1;
            end
        end
    end

    assign pwr_en = (state == PWR_ON);

    // R3
    disarmed_on_chk: assert property (@(posedge clk) disable iff (rst)
        !seq_en |=> pwr_en);

    // R4
    alarm_off_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_en && pwr_en && alarm_hit) |=> !pwr_en);

    // R7
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_en && !pwr_en && !wake_any) |=> (!pwr_en && !wake_evt));

    // R5
    evt_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        wake_evt |-> (pwr_en && !$past(pwr_en)));

endmodule

// File: rtl/pmic_pwr_ctrl.sv
module pmic_pwr_ctrl
    import pmic_pwr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h98,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W/8-1:0] cfg_be,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic                alarm_hit,
    input  logic [WAKE_N-1:0]   wake_pin,
    output logic                pwr_en,
    output logic                wake_evt
);
    pwr_cfg_t          cfg;
    logic [WAKE_N-1:0] pin_sync;
    logic              wake_any;

    pwr_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(CTRL_OFFSET)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .be(cfg_be), .wdata(cfg_wdata), .cfg(cfg)
    );

    wake_sync #(.WIDTH(WAKE_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_async(wake_pin), .pin_sync(pin_sync)
    );

    wake_detect #(.WIDTH(WAKE_N)) u_det (
        .pin_sync(pin_sync), .act_low(cfg.act_low),
        .enable(cfg.enable), .wake_any(wake_any)
    );

    pwr_seq u_seq (
        .clk(clk), .rst(rst), .seq_en(cfg.seq_en), .alarm_hit(alarm_hit),
        .wake_any(wake_any), .pwr_en(pwr_en), .wake_evt(wake_evt)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (pwr_en && !wake_evt));

endmodule

// File: tb/pmic_pwr_ctrl_test.sv
module pmic_pwr_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic        alarm_hit = 1'b0;
    logic [3:0]  wake_pin = 4'h0;
    logic        pwr_en;
    logic        wake_evt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pmic_pwr_ctrl uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .alarm_hit(alarm_hit),
        .wake_pin(wake_pin), .pwr_en(pwr_en), .wake_evt(wake_evt)
    );

    // vector fields: {enable[3:0], act_low[3:0], idle pins, active pins, expect on}
    localparam logic [16:0] VEC [8] = '{
        {4'b0001, 4'b0000, 4'b0000, 4'b0001, 1'b1},
        {4'b0001, 4'b0001, 4'b0001, 4'b0000, 1'b1},
        {4'b0001, 4'b0001, 4'b0001, 4'b0001, 1'b0},
        {4'b0100, 4'b0000, 4'b0000, 4'b1011, 1'b0},
        {4'b1000, 4'b1000, 4'b1000, 4'b0000, 1'b1},
        {4'b0000, 4'b0000, 4'b0000, 4'b1111, 1'b0},
        {4'b1111, 4'b1010, 4'b1010, 4'b1011, 1'b1},
        {4'b0010, 4'b0000, 4'b0000, 4'b0010, 1'b1}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_be = b; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_alarm();
        @(negedge clk);
        alarm_hit = 1'b1;
        @(negedge clk);
        alarm_hit = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pwr_en after reset", pwr_en, 1'b1);
        check("R1 wake_evt after reset", wake_evt, 1'b0);
        pulse_alarm();
        check("R1 control word zero, alarm ignored", pwr_en, 1'b1);

        // R3: disarmed, alarm has no effect
        wr(8'h98, 4'hF, 32'h0000_00FF);
        pulse_alarm();
        check("R3 alarm with bit16 clear", pwr_en, 1'b1);

        // R2: rejected writes
        wr(8'h9C, 4'hF, 32'h0001_0000);
        pulse_alarm();
        check("R2 wrong address ignored", pwr_en, 1'b1);
        wr(8'h98, 4'b0111, 32'h0001_0000);
        pulse_alarm();
        check("R2 partial strobes ignored", pwr_en, 1'b1);
        wr(8'h98, 4'hF, 32'h0001_0000);
        pulse_alarm();
        check("R2 R4 full write accepted, alarm turns off", pwr_en, 1'b0);

        // R8: disarm while off
        wr(8'h98, 4'hF, 32'h0000_0000);
        @(negedge clk);
        check("R8 power back on after disarm", pwr_en, 1'b1);
        check("R8 no wake_evt on disarm", wake_evt, 1'b0);

        // vector table: R4, R5, R6, R7
        for (int v = 0; v < 8; v++) begin
            logic [3:0] en, pol, idle, act;
            logic exp;
            {en, pol, idle, act, exp} = VEC[v];
            @(negedge clk);
            wake_pin = idle;
            wr(8'h98, 4'hF, {15'd0, 1'b1, 8'd0, pol, en});
            repeat (3) @(negedge clk);
            pulse_alarm();
            check("R4 alarm turns power off", pwr_en, 1'b0);
            wake_pin = act;
            repeat (2) @(negedge clk);
            check("R5 no early restore before third edge", pwr_en, 1'b0);
            @(negedge clk);
            check("R5 R6 R7 pwr_en after pin change", pwr_en, exp);
            check("R5 R6 R7 wake_evt after pin change", wake_evt, exp);
            @(negedge clk);
            check("R5 wake_evt lasts one cycle", wake_evt, 1'b0);
            wake_pin = idle;
            wr(8'h98, 4'hF, 32'h0);
            repeat (2) @(negedge clk);
        end

        // R9: wake pin active while power on
        wake_pin = 4'b0001;
        wr(8'h98, 4'hF, 32'h0001_0001);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R9 no wake_evt while on", wake_evt, 1'b0);
            check("R9 pwr_en stays on", pwr_en, 1'b1);
        end
        wake_pin = 4'b0000;
        wr(8'h98, 4'hF, 32'h0);
        repeat (3) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule